// File: doc/BRIEF.md
# Timer Slave Mode Counter

This block is the counting core of a general-purpose timer, together with the logic that lets an outside signal control it. The counter is 16 bits wide by default. A 3-bit mode input picks one of eight behaviours, and each one starts, stops, clears or clocks the counter in its own way. One mode leaves the counter on the internal prescaler tick. Three modes turn the two channel inputs into a quadrature position counter. The other four let the trigger input clear the counter, gate it, start it, or clock it.

The trigger input arrives already selected by the surrounding timer. A companion flag marks the case where that trigger is a both-edge source, which gives one pulse per transition rather than a level. A software strobe word can force an update event and can force a trigger event. Every count wraps against a reload value, and each wrap raises a one-cycle update pulse. Inputs are sampled on the rising clock edge, and the registered outputs change on that same edge.

Top module: `slave_timer_core`

## Requirements
- R1: In mode 0, the count rises by 1 on each cycle where `tick` and `cnt_en` are both 1. When the count has reached `reload_val` or more, the next step loads 0 and pulses `upd_evt` for one cycle. With `cnt_en` at 0 the count holds.
- R2: In mode 1, the counter steps only on a change of `ch1_in`, and only when `cnt_en` is 1. The step is up when the new `ch1_in` differs from `ch2_in`, and down otherwise. `tick` is ignored.
- R3: In mode 2, the counter steps only on a change of `ch2_in`, and only when `cnt_en` is 1. The step is up when the new `ch2_in` equals `ch1_in`, and down otherwise.
- R4: In mode 3, a change of either channel steps the counter, using the R2 rule for `ch1_in` and the R3 rule for `ch2_in`. When both channels change in the same cycle, the counter does not step.
- R5: In the encoder modes (1 to 3), `dir_down` shows the direction of the last step. A down step from 0 loads `reload_val` and pulses `upd_evt`. In modes 0 and 4 to 7, `dir_down` is 0.
- R6: In mode 4, a rising trigger edge loads 0 into the count and pulses `upd_evt`. In every other cycle, the counter behaves as in R1.
- R7: In mode 5, the count rises on `tick` only while `cnt_en` is 1 and `trig_in` is high. When `trig_in` is low the count holds and is not cleared.
- R8: In mode 6, a rising trigger edge (or the software trigger bit) starts the counter, and counting begins on the next cycle even with `cnt_en` at 0. Later trigger edges do not stop it. Leaving mode 6 cancels the start.
- R9: In mode 7, each rising trigger edge adds 1 to the count while `cnt_en` is 1. `tick` is ignored.
- R10: `cfg_illegal` is 1 exactly when the mode is 5 and `trig_both_edge` is 1. While the combination is illegal, the count does not advance.
- R11: Bit 0 of `sw_evt` loads 0 into the count and pulses `upd_evt` on the next cycle. It takes priority over any counting. Bits 1 to 5 have no effect.
- R12: `trig_evt` pulses for one cycle after bit 6 of `sw_evt` in any mode. It also pulses after a rising trigger edge in modes 4 to 7.
- R13: While `rst_n` is low, `count` is 0, `dir_down` is 0, `upd_evt` is 0 and `trig_evt` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick | input | 1 | Internal count enable from the prescaler |
| ch1_in | input | 1 | Filtered channel 1 level |
| ch2_in | input | 1 | Filtered channel 2 level |
| trig_in | input | 1 | Selected trigger signal |
| trig_both_edge | input | 1 | Trigger is a per-transition pulse source |
| cnt_en | input | 1 | Counter enable |
| slave_mode | input | 3 | Slave behaviour select (0 to 7 as in R1 to R9) |
| reload_val | input | CNT_W | Auto-reload value |
| sw_evt | input | 7 | Software strobes: bit 0 update, bit 6 trigger |
| count | output | CNT_W | Counter value |
| dir_down | output | 1 | Last encoder step was downward |
| upd_evt | output | 1 | One-cycle update event |
| trig_evt | output | 1 | One-cycle trigger event |
| cfg_illegal | output | 1 | Gated mode with both-edge trigger |

## Verification
The bench builds the block with the default `CNT_W` of 16. It drives `reload_val` with small values (4 to 6), so the upward wrap and the downward wrap from 0 both occur within a few steps. Quadrature phases are driven forward and in reverse, plus one simultaneous change of both channels. The trigger is pulsed while each of modes 4 to 7 is active, and the software strobes are mixed into counting. The reference model follows every cycle.

// File: rtl/slv_pkg.sv
package slv_pkg;

  typedef enum logic [2:0] {
    SM_OFF     = 3'd0,
    SM_ENC_A   = 3'd1,
    SM_ENC_B   = 3'd2,
    SM_ENC_AB  = 3'd3,
    SM_RESET   = 3'd4,
    SM_GATED   = 3'd5,
    SM_TRIGGER = 3'd6,
    SM_EXTCLK  = 3'd7
  } slv_mode_e;

  localparam int SW_W   = 7;
  localparam int SW_UPD = 0;
  localparam int SW_TRG = 6;

  // Direction for a step caused by a change of channel 1.
  function automatic logic enc_up_on_a(input logic a, input logic b);
    return a ^ b;
  endfunction

  // Direction for a step caused by a change of channel 2.
  function automatic logic enc_up_on_b(input logic a, input logic b);
    return ~(a ^ b);
  endfunction

  function automatic logic is_encoder(input slv_mode_e m);
    return (m == SM_ENC_A) || (m == SM_ENC_B) || (m == SM_ENC_AB);
  endfunction

endpackage

// File: rtl/slv_edge_det.sv
module slv_edge_det #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] din,
  output logic [N-1:0] chg
);
  logic [N-1:0] din_q;

  for (genvar i = 0; i < N; i++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) din_q[i] <= 1'b0;
      else        din_q[i] <= din[i];
    end
    assign chg[i] = din[i] ^ din_q[i];
  end
endmodule

// File: rtl/slv_quad_dec.sv
module slv_quad_dec
  import slv_pkg::*;
(
  input  slv_mode_e mode,
  input  logic      ch_a,
  input  logic      ch_b,
  input  logic      chg_a,
  input  logic      chg_b,
  output logic      step,
  output logic      up
);
  always_comb begin
    step = 1'b0;
    up   = 1'b1;
    case (mode)
      SM_ENC_A: begin
        step = chg_a;
        up   = enc_up_on_a(ch_a, ch_b);
      end
      SM_ENC_B: begin
        step = chg_b;
        up   = enc_up_on_b(ch_a, ch_b);
      end
      SM_ENC_AB: begin
        step = chg_a ^ chg_b;
        up   = chg_a ? enc_up_on_a(ch_a, ch_b) : enc_up_on_b(ch_a, ch_b);
      end
      default: begin
        step = 1'b0;
        up   = 1'b1;
      end
    endcase
  end
endmodule

// File: rtl/slv_slave_ctrl.sv
module slv_slave_ctrl
  import slv_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  slv_mode_e mode,
  input  logic      tick,
  input  logic      en,
  input  logic      trig_lvl,
  input  logic      trig_rise,
  input  logic      both_edge,
  input  logic      sw_trg,
  input  logic      enc_step,
  output logic      cnt_step,
  output logic      reinit,
  output logic      illegal
);
  logic start_q;

  assign illegal = (mode == SM_GATED) && both_edge;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      start_q <= 1'b0;
    else if (mode != SM_TRIGGER)     start_q <= 1'b0;
    else if (trig_rise || sw_trg)    start_q <= 1'b1;
  end

  always_comb begin
    cnt_step = 1'b0;
    reinit   = 1'b0;
    case (mode)
      SM_OFF:     cnt_step = en & tick;
      SM_ENC_A,
      SM_ENC_B,
      SM_ENC_AB:  cnt_step = en & enc_step;
      SM_RESET: begin
        reinit   = trig_rise;
        cnt_step = en & tick & ~trig_rise;
      end
      SM_GATED:   cnt_step = en & tick & trig_lvl & ~illegal;
      SM_TRIGGER: cnt_step = (en | start_q) & tick;
      SM_EXTCLK:  cnt_step = en & trig_rise;
      default:    cnt_step = 1'b0;
    endcase
  end
endmodule

// File: rtl/slv_counter.sv
module slv_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  input  logic             down,
  input  logic             reinit,
  input  logic [CNT_W-1:0] arr,
  output logic [CNT_W-1:0] count,
  output logic             upd_evt
);
  localparam logic [CNT_W-1:0] ZERO = '0;
  localparam logic [CNT_W-1:0] ONE  = {{(CNT_W-1){1'b0}}, 1'b1};

  function automatic logic wraps(input logic [CNT_W-1:0] c,
                                 input logic [CNT_W-1:0] r, input logic dn);
    return dn ? (c == ZERO) : (c >= r);
  endfunction

  function automatic logic [CNT_W-1:0] advance(input logic [CNT_W-1:0] c,
                                               input logic [CNT_W-1:0] r,
                                               input logic dn);
    if (dn) return (c == ZERO) ? r : c - ONE;
    return (c >= r) ? ZERO : c + ONE;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count   <= ZERO;
      upd_evt <= 1'b0;
    end else if (reinit) begin
      count   <= ZERO;
      upd_evt <= 1'b1;
    end else if (step) begin
      count   <= advance(count, arr, down);
      upd_evt <= wraps(count, arr, down);
    end else begin
      upd_evt <= 1'b0;
    end
  end
endmodule

// File: rtl/slave_timer_core.sv
module slave_timer_core
  import slv_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             ch1_in,
  input  logic             ch2_in,
  input  logic             trig_in,
  input  logic             trig_both_edge,
  input  logic             cnt_en,
  input  logic [2:0]       slave_mode,
  input  logic [CNT_W-1:0] reload_val,
  input  logic [SW_W-1:0]  sw_evt,
  output logic [CNT_W-1:0] count,
  output logic             dir_down,
  output logic             upd_evt,
  output logic             trig_evt,
  output logic             cfg_illegal
);
  slv_mode_e  mode;
  logic [2:0] chg;
  logic       trig_rise;
  logic       enc_step, enc_up;
  logic       ctr_step, ctl_reinit, ctr_reinit, ctr_down, enc_mode;
  logic       sw_cc_unused;

  assign mode         = slv_mode_e'(slave_mode);
  assign sw_cc_unused = ^sw_evt[5:1];

  slv_edge_det #(.N(3)) u_edge (
    .clk  (clk),
    .rst_n(rst_n),
    .din  ({trig_in, ch2_in, ch1_in}),
    .chg  (chg)
  );

  assign trig_rise = chg[2] & trig_in;

  slv_quad_dec u_quad (
    .mode (mode),
    .ch_a (ch1_in),
    .ch_b (ch2_in),
    .chg_a(chg[0]),
    .chg_b(chg[1]),
    .step (enc_step),
    .up   (enc_up)
  );

  slv_slave_ctrl u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .mode     (mode),
    .tick     (tick),
    .en       (cnt_en),
    .trig_lvl (trig_in),
    .trig_rise(trig_rise),
    .both_edge(trig_both_edge),
    .sw_trg   (sw_evt[SW_TRG]),
    .enc_step (enc_step),
    .cnt_step (ctr_step),
    .reinit   (ctl_reinit),
    .illegal  (cfg_illegal)
  );

  assign enc_mode   = is_encoder(mode);
  assign ctr_down   = enc_mode & ~enc_up;
  assign ctr_reinit = ctl_reinit | sw_evt[SW_UPD];

  slv_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk    (clk),
    .rst_n  (rst_n),
    .step   (ctr_step),
    .down   (ctr_down),
    .reinit (ctr_reinit),
    .arr    (reload_val),
    .count  (count),
    .upd_evt(upd_evt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_down <= 1'b0;
      trig_evt <= 1'b0;
    end else begin
      if (!enc_mode)     dir_down <= 1'b0;
      else if (ctr_step) dir_down <= ctr_down;
      trig_evt <= sw_evt[SW_TRG] | (trig_rise & slave_mode[2]);
    end
  end
endmodule

// File: rtl/slave_timer_core_chk.sv
module slave_timer_core_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic [2:0]       slave_mode,
  input logic             cnt_en,
  input logic [6:0]       sw_evt,
  input logic             trig_in,
  input logic             trig_rise,
  input logic [CNT_W-1:0] count,
  input logic             upd_evt,
  input logic             trig_evt,
  input logic             cfg_illegal
);
  AST_OFF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (slave_mode == 3'd0 && !cnt_en && !sw_evt[0]) |=> $stable(count)); // R1
  AST_RESET_MODE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (slave_mode == 3'd4 && trig_rise) |=> (upd_evt && count == '0)); // R6
  AST_GATE_LOW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (slave_mode == 3'd5 && !trig_in && !sw_evt[0]) |=> $stable(count)); // R7
  AST_EXT_NO_EDGE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (slave_mode == 3'd7 && !trig_rise && !sw_evt[0]) |=> $stable(count)); // R9
  AST_ILLEGAL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_illegal && !sw_evt[0]) |=> $stable(count)); // R10
  AST_SW_UPDATE: assert property (@(posedge clk) disable iff (!rst_n)
    sw_evt[0] |=> (upd_evt && count == '0)); // R11
  AST_SW_TRIGGER: assert property (@(posedge clk) disable iff (!rst_n)
    sw_evt[6] |=> trig_evt); // R12
endmodule

bind slave_timer_core slave_timer_core_chk #(.CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .slave_mode (slave_mode),
  .cnt_en     (cnt_en),
  .sw_evt     (sw_evt),
  .trig_in    (trig_in),
  .trig_rise  (trig_rise),
  .count      (count),
  .upd_evt    (upd_evt),
  .trig_evt   (trig_evt),
  .cfg_illegal(cfg_illegal)
);

// File: tb/slave_timer_core_bench.sv
`timescale 1ns/1ps
module slave_timer_core_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 0, ch1 = 0, ch2 = 0, trg = 0, both = 0, en = 0;
  logic [2:0]  mode = 0;
  logic [15:0] arr = 16'd5;
  logic [6:0]  sw = 0;
  logic [15:0] count;
  logic        dir_down, upd_evt, trig_evt, cfg_illegal;

  always #10 clk = ~clk;

  slave_timer_core u_slave_timer_core (
    .clk(clk), .rst_n(rst_n), .tick(tick), .ch1_in(ch1), .ch2_in(ch2),
    .trig_in(trg), .trig_both_edge(both), .cnt_en(en), .slave_mode(mode),
    .reload_val(arr), .sw_evt(sw), .count(count), .dir_down(dir_down),
    .upd_evt(upd_evt), .trig_evt(trig_evt), .cfg_illegal(cfg_illegal)
  );

  int total = 0, bad = 0;
  string cur_req = "R13";
  int m_cnt = 0, m_dir = 0, m_upd = 0, m_trg = 0, m_start = 0;
  int p1 = 0, p2 = 0, pt = 0;

  task automatic chk(string req, string what, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Behavioural reference: computes the state the design holds after the next edge.
  task automatic model_step();
    int i1 = ch1, i2 = ch2, it = trg, md = mode, r = arr;
    bit e1 = (i1 != p1), e2 = (i2 != p2), trise = (it == 1 && pt == 0);
    int delta = 0;
    bit reinit = 0;
    m_upd = 0;
    m_trg = (sw[6] || (trise && md >= 4)) ? 1 : 0;
    case (md)
      0: if (en && tick) delta = 1;
      1: if (en && e1) delta = (i1 != i2) ? 1 : -1;
      2: if (en && e2) delta = (i2 == i1) ? 1 : -1;
      3: if (en && (e1 != e2)) begin
           if (e1) delta = (i1 != i2) ? 1 : -1;
           else    delta = (i2 == i1) ? 1 : -1;
         end
      4: if (trise) reinit = 1; else if (en && tick) delta = 1;
      5: if (en && tick && it == 1 && !both) delta = 1;
      6: if ((en || m_start == 1) && tick) delta = 1;
      default: if (en && trise) delta = 1;
    endcase
    if (md == 6) begin
      if (trise || sw[6]) m_start = 1;
    end else m_start = 0;
    if (md >= 1 && md <= 3) begin
      if (delta != 0) m_dir = (delta < 0) ? 1 : 0;
    end else m_dir = 0;
    if (sw[0] || reinit) begin
      m_cnt = 0; m_upd = 1;
    end else if (delta > 0) begin
      if (m_cnt >= r) begin m_cnt = 0; m_upd = 1; end else m_cnt++;
    end else if (delta < 0) begin
      if (m_cnt == 0) begin m_cnt = r; m_upd = 1; end else m_cnt--;
    end
    p1 = i1; p2 = i2; pt = it;
  endtask

  task automatic cyc();
    model_step();
    @(negedge clk);
    total++;
    if (count != m_cnt[15:0] || dir_down != m_dir[0] || upd_evt != m_upd[0] ||
        trig_evt != m_trg[0] || cfg_illegal != (mode == 3'd5 && both)) begin
      bad++;
      $display("FAIL %s actual cnt=%0d dir=%0d upd=%0d trg=%0d ill=%0d expected cnt=%0d dir=%0d upd=%0d trg=%0d ill=%0d",
               cur_req, count, dir_down, upd_evt, trig_evt, cfg_illegal,
               m_cnt, m_dir, m_upd, m_trg, (mode == 3'd5 && both));
    end
  endtask

  function automatic bit ph_a(int ph); return (ph == 1 || ph == 2); endfunction
  function automatic bit ph_b(int ph); return (ph == 2 || ph == 3); endfunction

  task automatic quad(int steps, int fwd);
    int ph = 0;
    if (ch1 && !ch2) ph = 1; else if (ch1 && ch2) ph = 2; else if (ch2) ph = 3;
    for (int k = 0; k < steps; k++) begin
      ph = fwd ? (ph + 1) % 4 : (ph + 3) % 4;
      ch1 = ph_a(ph); ch2 = ph_b(ph);
      cyc();
    end
  endtask

  task automatic pulse_trig();
    trg = 1; cyc(); trg = 0; cyc();
  endtask

  initial begin
    #(200000 * 20);
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R13 reset state
    chk("R13", "count", count, 0);
    chk("R13", "dir_down", dir_down, 0);
    chk("R13", "upd_evt", upd_evt, 0);
    chk("R13", "trig_evt", trig_evt, 0);
    rst_n = 1;

    cur_req = "R1"; mode = 0; arr = 4; en = 1;
    for (int k = 0; k < 14; k++) begin tick = k[0]; cyc(); end
    tick = 1; for (int k = 0; k < 6; k++) cyc();
    en = 0; for (int k = 0; k < 4; k++) cyc();

    cur_req = "R11"; sw = 7'h01; cyc(); sw = 0; en = 1; cyc(); cyc();
    sw = 7'h3E; for (int k = 0; k < 4; k++) cyc();
    sw = 7'h01; cyc(); sw = 0; cyc();

    cur_req = "R2"; mode = 1; tick = 1; arr = 6; quad(8, 1);
    cur_req = "R5"; quad(10, 0);
    chk("R5", "dir_down after reverse", dir_down, 1);
    cur_req = "R3"; mode = 2; quad(8, 1); quad(4, 0);
    cur_req = "R4"; mode = 3; quad(12, 1);
    ch1 = ~ch1; ch2 = ~ch2; cyc(); cyc();
    cur_req = "R5"; quad(16, 0);
    en = 0; quad(4, 1); en = 1;

    cur_req = "R6"; mode = 4; arr = 5; tick = 1;
    for (int k = 0; k < 4; k++) cyc();
    pulse_trig(); cyc(); cyc(); pulse_trig();
    for (int k = 0; k < 8; k++) cyc();

    cur_req = "R7"; mode = 5; trg = 1;
    for (int k = 0; k < 3; k++) cyc();
    trg = 0; for (int k = 0; k < 4; k++) cyc();
    trg = 1; for (int k = 0; k < 3; k++) cyc();
    cur_req = "R10"; both = 1;
    for (int k = 0; k < 4; k++) cyc();
    chk("R10", "cfg_illegal", cfg_illegal, 1);
    both = 0; trg = 0; cyc();

    cur_req = "R8"; mode = 6; en = 0; tick = 1;
    for (int k = 0; k < 3; k++) cyc();
    pulse_trig(); for (int k = 0; k < 3; k++) cyc();
    pulse_trig(); for (int k = 0; k < 3; k++) cyc();
    mode = 0; for (int k = 0; k < 3; k++) cyc();
    cur_req = "R12"; mode = 6; sw = 7'h40; cyc(); sw = 0;
    for (int k = 0; k < 4; k++) cyc();
    mode = 0; sw = 7'h40; cyc(); sw = 0; cyc();

    cur_req = "R9"; mode = 7; en = 1; tick = 1;
    for (int k = 0; k < 8; k++) pulse_trig();
    tick = 0; for (int k = 0; k < 3; k++) cyc();

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule